// File: doc/BRIEF.md
# Serial Two's Complement Negator

This block keeps a word of parameterized width in a shift register and turns it, in place, into its two's complement (its arithmetic negation modulo 2^N). It needs no adder and no parallel inverter. Instead it walks the word one bit per clock, starting at the least significant bit. A single sticky flag records whether a '1' has already gone past. Each outgoing bit is XORed with that flag, so every bit up to and including the lowest '1' passes through unchanged and every bit above it is inverted. The produced bit re-enters the register at the most significant end. After N shift clocks the register holds the negated word.

A client writes a word through the parallel load port with a load strobe while the block is idle. It then pulses the start strobe. For N cycles the block emits the result bits on the serial output. It then raises a one-cycle done pulse, and at that point the parallel output holds the result.

Top module: `twos_neg_shifter`

## Requirements
- R1: When the block is idle and load_i is high at a clock edge, word_o shows load_word_i after that edge.
- R2: When the block is idle and start_i is high (with load_i low) at a clock edge, a conversion begins and the sticky flag is cleared. If load_i and start_i are both high, the load takes effect and the start is ignored, so no done pulse follows.
- R3: During a conversion the bits are consumed least significant first. In cycle k after the start edge (k = 0..N-1), serial_o equals bit k of the negated word. While the block is idle, serial_o is 0.
- R4: The flag becomes set in the cycle after the first '1' is consumed and stays set until the next start. Every bit consumed while the flag is set comes out inverted.
- R5: Exactly N shift clocks after the start edge, done_o is high for one cycle and word_o equals (2^N - x) mod 2^N for the loaded word x. With N = 8, the word 00011100 gives 11100100.
- R6: Each result bit enters the register at bit position N-1, and the word moves one place toward bit 0 on every shift.
- R7: While a conversion is running, start_i and load_i have no effect: the result and the timing of done_o do not change.
- R8: An all-zero word negates to all zeros. The word with only the most significant bit set negates to itself.
- R9: A synchronous active-high rst returns the block to idle and clears the word, the flag and the bit counter. done_o and serial_o are then 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Captures load_word_i while idle |
| load_word_i | input | W | Parallel word to negate |
| start_i | input | 1 | Begins a conversion while idle |
| word_o | output | W | Register contents; holds the result when done_o is high |
| serial_o | output | 1 | Result bit for the current shift, LSB first |
| done_o | output | 1 | One-cycle pulse after the last shift |

## Verification
The assertions check the following on every cycle:
- the flag is clear when a conversion begins, and it never falls while the conversion is running;
- whenever the flag is set, serial_o is the inverse of the register's low bit;
- done_o is a single-cycle pulse that follows only the final shift;
- a start during a conversion does not end it.

The exact negated values, the bit order on the serial output, the load-over-start priority and the corner words can only be shown by the bench's scenarios, because each of them compares whole words against an independently computed negation.

// File: rtl/twos_neg_pkg.sv
package twos_neg_pkg;
    typedef enum logic [0:0] {
        MODE_IDLE = 1'b0,
        MODE_RUN  = 1'b1
    } neg_mode_e;
endpackage

// File: rtl/tc_bit_cell.sv
// One serial negation step: pass the bit until a '1' has gone past, then invert.
module tc_bit_cell (
    input  logic x_i,
    input  logic flag_i,
    output logic y_o,
    output logic flag_nxt_o
);
    always_comb begin
        y_o        = x_i ^ flag_i;
        flag_nxt_o = x_i | flag_i;
    end
endmodule

// File: rtl/tc_step_counter.sv
// Counts shift clocks; last_o marks the final shift of a conversion.
module tc_step_counter #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic en_i,
    output logic last_o
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(W - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (en_i) begin
            cnt_d = (cnt_q == LAST_CNT) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == LAST_CNT);
endmodule

// File: rtl/twos_neg_shifter.sv
module twos_neg_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_word_i,
    input  logic         start_i,
    output logic [W-1:0] word_o,
    output logic         serial_o,
    output logic         done_o
);
    import twos_neg_pkg::*;

    typedef struct packed {
        neg_mode_e    mode;
        logic         flag;
        logic [W-1:0] word;
        logic         done;
    } neg_state_t;

    neg_state_t st_d, st_q;

    logic y_w, flag_nxt_w, last_w, run_w, flag_w, begin_w;

    assign run_w  = (st_q.mode == MODE_RUN);
    assign flag_w = st_q.flag;
    // A start is taken only while idle, and only when no load is requested.
    assign begin_w = !run_w && start_i && !load_i;

    tc_bit_cell u_cell (
        .x_i        (st_q.word[0]),
        .flag_i     (st_q.flag),
        .y_o        (y_w),
        .flag_nxt_o (flag_nxt_w)
    );

    tc_step_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (begin_w),
        .en_i   (run_w),
        .last_o (last_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.mode)
            MODE_IDLE: begin
                if (load_i) begin
                    st_d.word = load_word_i;
                end else if (start_i) begin
                    st_d.mode = MODE_RUN;
                    st_d.flag = 1'b0;
                end
            end
            MODE_RUN: begin
                st_d.word = {y_w, st_q.word[W-1:1]};
                st_d.flag = flag_nxt_w;
                if (last_w) begin
                    st_d.mode = MODE_IDLE;
                    st_d.done = 1'b1;
                end
            end
            default: st_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= MODE_IDLE;
            st_q.flag <= 1'b0;
            st_q.word <= '0;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o   = st_q.word;
    assign serial_o = run_w ? y_w : 1'b0;
    assign done_o   = st_q.done;
endmodule

// File: rtl/tc_neg_checker.sv
module tc_neg_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic [W-1:0] word_o,
    input logic         serial_o,
    input logic         done_o,
    input logic         run,
    input logic         flag,
    input logic         last
);
    // R2
    flag_clear_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> !flag);

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (run && flag) |=> flag);

    // R4
    invert_after_one_chk: assert property (@(posedge clk) disable iff (rst)
        (run && flag) |-> (serial_o != word_o[0]));

    // R3
    idle_serial_low_chk: assert property (@(posedge clk) disable iff (rst)
        !run |-> !serial_o);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R5
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (run && last) |=> (done_o && !run));

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !last && start_i) |=> run);

    // R9
    reset_clears_chk: assert property (@(posedge clk)
        $past(rst) |-> (!done_o && !run && word_o == '0));
endmodule

bind twos_neg_shifter tc_neg_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .word_o   (word_o),
    .serial_o (serial_o),
    .done_o   (done_o),
    .run      (run_w),
    .flag     (flag_w),
    .last     (last_w)
);

// File: tb/sim_twos_neg_shifter.sv
module sim_twos_neg_shifter;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;
    localparam int NVEC = 8;
    localparam logic [W-1:0] VEC [NVEC] = '{
        8'b0001_1100, 8'h00, 8'h80, 8'h01, 8'hFF, 8'h7F, 8'h55, 8'hA6
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_i = 1'b0;
    logic start_i = 1'b0;
    logic [W-1:0] load_word_i = '0;
    logic [W-1:0] word_o;
    logic serial_o, done_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    twos_neg_shifter #(.W(W)) u0 (
        .clk(clk), .rst(rst), .load_i(load_i), .load_word_i(load_word_i),
        .start_i(start_i), .word_o(word_o), .serial_o(serial_o), .done_o(done_o)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [W-1:0] v);
        @(negedge clk);
        load_i = 1'b1; load_word_i = v;
        @(negedge clk);
        load_i = 1'b0;
        chk("R1 load", word_o, v);
    endtask

    // Runs a full conversion from the current word; optional disturbance at step 3.
    task automatic run_conv(input logic [W-1:0] x, input bit disturb);
        logic [W-1:0] exp;
        exp = (~x) + 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < W; k++) begin
            chk("R3 serial bit", {7'b0, serial_o}, {7'b0, exp[k]});
            chk("R5 no early done", {7'b0, done_o}, 8'h0);
            if (k == 2) chk("R6 msb entry", {5'b0, word_o[W-1:W-2], 1'b0}, {5'b0, exp[1:0], 1'b0});
            if (disturb && k == 3) begin
                start_i = 1'b1; load_i = 1'b1; load_word_i = 8'h3C;
            end else begin
                start_i = 1'b0; load_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0; load_i = 1'b0;
        chk(disturb ? "R7 ignored result" : "R5 result", word_o, exp);
        chk("R5 done pulse", {7'b0, done_o}, 8'h1);
        chk("R3 idle serial", {7'b0, serial_o}, 8'h0);
        @(negedge clk);
        chk("R5 done one cycle", {7'b0, done_o}, 8'h0);
        chk("R5 result held", word_o, exp);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                chk("R9 reset word", word_o, 8'h00);
                chk("R9 reset done", {7'b0, done_o}, 8'h0);

                for (int i = 0; i < NVEC; i++) begin
                    do_load(VEC[i]);
                    run_conv(VEC[i], 1'b0);
                end

                // R8 explicit corners
                do_load(8'h00);
                run_conv(8'h00, 1'b0);
                chk("R8 zero", word_o, 8'h00);
                do_load(8'h80);
                run_conv(8'h80, 1'b0);
                chk("R8 most negative", word_o, 8'h80);

                // R7: start and load pulsed mid-conversion
                do_load(8'b0001_1100);
                run_conv(8'b0001_1100, 1'b1);

                // R2: load and start together -> load wins, no conversion
                @(negedge clk);
                load_i = 1'b1; start_i = 1'b1; load_word_i = 8'h5A;
                @(negedge clk);
                load_i = 1'b0; start_i = 1'b0;
                chk("R2 load wins", word_o, 8'h5A);
                chk("R2 no run serial", {7'b0, serial_o}, 8'h0);
                for (int k = 0; k < W + 2; k++) begin
                    chk("R2 no done", {7'b0, done_o}, 8'h0);
                    @(negedge clk);
                end
                chk("R2 word unchanged", word_o, 8'h5A);

                // R9: reset in mid-conversion
                do_load(8'h6B);
                @(negedge clk); start_i = 1'b1;
                @(negedge clk); start_i = 1'b0;
                @(negedge clk); @(negedge clk);
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                chk("R9 word cleared", word_o, 8'h00);
                chk("R9 serial low", {7'b0, serial_o}, 8'h0);
                chk("R9 done low", {7'b0, done_o}, 8'h0);
                for (int k = 0; k < W + 2; k++) begin
                    chk("R9 idle after reset", {7'b0, done_o}, 8'h0);
                    @(negedge clk);
                end
                // R4: flag cleared by reset/start, fresh conversion correct
                do_load(8'h28);
                run_conv(8'h28, 1'b0);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule